// File: doc/BRIEF.md
# Conversion Data-Ready Flag Controller

This block sequences an active-low ready indicator for the result register of a converter. Five events drive it: a new result lands in the register, the serial interface finishes reading that register, a calibration finishes, software writes the mode register, and the conversion pipeline counts down the clocks left before the next register update. From these events the block decides, cycle by cycle, whether a host may start a read.

The indicator falls when a fresh result is stored and rises when a read of it has completed. When a result goes unread, the indicator rises a fixed number of clocks before the next update overwrites it. This means a host that sees it low never starts a read that the update would tear. After a calibration the indicator falls and stays low through reads and conversions until the mode register is written again. A status bit carries the same ready information for register readback, and the internal state is brought out as a 2-bit field.

Top module: `rdy_flag_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) `rdy_n_o` is 1, `rdy_stat_o` is 0 and `state_o` is 0 (idle).
- R2: A `new_result_i` pulse outside the calibration-held state makes `rdy_n_o` 0 and `state_o` 1 (valid) after the next clock edge.
- R3: In the valid state, a `read_done_i` pulse with no other event returns `rdy_n_o` to 1 and `state_o` to 0 after the next edge.
- R4: In the valid state, an `upd_cnt_i` value in the range 1 to `BLANK_CLKS` raises `rdy_n_o` and moves `state_o` to 2 (blanked). The blanked state holds until `new_result_i`, `mode_wr_i` or `cal_done_i` arrives.
- R5: `upd_cnt_i` values of 0 or above `BLANK_CLKS` have no effect on any state.
- R6: `cal_done_i` moves the block from any state to `state_o` 3 (calibration-held) with `rdy_n_o` 0. It has priority over every other input in the same cycle.
- R7: In the calibration-held state, `read_done_i`, `new_result_i` and any `upd_cnt_i` value are ignored. `rdy_n_o` stays 0.
- R8: `mode_wr_i` without `cal_done_i` moves any state to idle (`state_o` 0, `rdy_n_o` 1). It takes priority over `new_result_i`.
- R9: `new_result_i` and `read_done_i` in the same cycle leave the block valid with `rdy_n_o` 0. `new_result_i` also takes priority over a blanking count.
- R10: `read_done_i` while `rdy_n_o` is 1 (idle or blanked) leaves the state unchanged.
- R11: `rdy_stat_o` equals the inverse of `rdy_n_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| new_result_i | input | 1 | One-cycle pulse: a new result was written to the data register |
| read_done_i | input | 1 | One-cycle pulse: a read of the data register completed |
| cal_done_i | input | 1 | One-cycle pulse: a calibration cycle completed |
| mode_wr_i | input | 1 | One-cycle pulse: the mode register was written |
| upd_cnt_i | input | CNT_W | Clocks left until the next register update; 0 when none is pending |
| rdy_n_o | output | 1 | Active-low data-ready indicator |
| rdy_stat_o | output | 1 | Readback status bit, 1 when data is ready |
| state_o | output | 2 | Current state: 0 idle, 1 valid, 2 blanked, 3 calibration-held |

## Verification
The bench puts the block in each of its four states and applies every combination of the four strobes, paired with countdown values at and around both edges of the blanking window. This reaches the collisions where the requirements pick a winner.

Some wrong designs would show clear symptoms. A design that let a read win over a new result would raise the indicator while fresh data sat unread. Blanking only at a count of 1, or also at `BLANK_CLKS`+1, would break at the window edges. Releasing the calibration hold on a read or a new result would let the indicator rise before the mode write. Ranking the mode write above calibration-done would leave the block idle when it should be held.

// File: rtl/rdy_flag_pkg.sv
// Shared state encoding for the data-ready flag controller.
// Assumes: the 2-bit encoding is read by software and the bench, so values are fixed.
package rdy_flag_pkg;

    typedef enum logic [1:0] {
        RF_IDLE    = 2'd0,
        RF_VALID   = 2'd1,
        RF_BLANKED = 2'd2,
        RF_CALHOLD = 2'd3
    } rf_state_e;

endpackage

// File: rtl/rdy_upd_window.sv
// Decides whether the update countdown lies inside the pre-update blanking window.
// Assumes: a count of 0 means no update is pending; the window is 1..BLANK_CLKS.
module rdy_upd_window #(
    parameter int CNT_W      = 8,
    parameter int BLANK_CLKS = 3
) (
    input  logic [CNT_W-1:0] upd_cnt_i,
    output logic             in_window_o
);

    localparam int CNT_MAX = (1 << CNT_W) - 1;

    generate
        if (BLANK_CLKS >= CNT_MAX) begin : g_all_nonzero
            // Window covers every representable nonzero count.
            always_comb in_window_o = (upd_cnt_i != '0);
        end else begin : g_bounded
            localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BLANK_CLKS);
            // Window is bounded above by the parameter.
            always_comb in_window_o = (upd_cnt_i != '0) && (upd_cnt_i <= LIMIT);
        end
    endgenerate

endmodule

// File: rtl/rdy_next_state.sv
// Next-state logic for the ready flag: ranks the events and picks the successor state.
// Assumes: strobes are single-cycle pulses; priority is cal_done > mode_wr > new_result
// > blanking window > read_done, and the calibration hold yields only to mode_wr.
module rdy_next_state
    import rdy_flag_pkg::*;
(
    input  rf_state_e state_i,
    input  logic      new_result_i,
    input  logic      read_done_i,
    input  logic      cal_done_i,
    input  logic      mode_wr_i,
    input  logic      in_window_i,
    output rf_state_e state_o
);

    // Successor state from current state and the prioritised events.
    always_comb begin
        state_o = state_i;
        if (cal_done_i) begin
            state_o = RF_CALHOLD;
        end else if (state_i == RF_CALHOLD) begin
            if (mode_wr_i) state_o = RF_IDLE;
        end else if (mode_wr_i) begin
            state_o = RF_IDLE;
        end else if (new_result_i) begin
            state_o = RF_VALID;
        end else if (state_i == RF_VALID) begin
            if (in_window_i)      state_o = RF_BLANKED;
            else if (read_done_i) state_o = RF_IDLE;
        end
    end

endmodule

// File: rtl/rdy_flag_ctrl.sv
// Data-ready flag controller: holds the flag state and drives the active-low
// ready output plus its readback mirror.
// Assumes: one clock domain, synchronous active-low reset, inputs already synchronous.
module rdy_flag_ctrl
    import rdy_flag_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int BLANK_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_result_i,
    input  logic             read_done_i,
    input  logic             cal_done_i,
    input  logic             mode_wr_i,
    input  logic [CNT_W-1:0] upd_cnt_i,
    output logic             rdy_n_o,
    output logic             rdy_stat_o,
    output logic [1:0]       state_o
);

    rf_state_e state_q;
    rf_state_e state_d;
    logic      in_window;

    rdy_upd_window #(
        .CNT_W      (CNT_W),
        .BLANK_CLKS (BLANK_CLKS)
    ) i_window (
        .upd_cnt_i   (upd_cnt_i),
        .in_window_o (in_window)
    );

    rdy_next_state i_next (
        .state_i      (state_q),
        .new_result_i (new_result_i),
        .read_done_i  (read_done_i),
        .cal_done_i   (cal_done_i),
        .mode_wr_i    (mode_wr_i),
        .in_window_i  (in_window),
        .state_o      (state_d)
    );

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RF_IDLE;
        else        state_q <= state_d;
    end

    // Output decode: ready only in the valid and calibration-held states.
    always_comb begin
        rdy_stat_o = (state_q == RF_VALID) || (state_q == RF_CALHOLD);
        rdy_n_o    = !rdy_stat_o;
        state_o    = state_q;
    end

    // R1: reset leaves the indicator high.
    assert_reset_high_R1: assert property (@(posedge clk) !rst_n |=> rdy_n_o);

    // R2: a new result outside the hold drives the indicator low.
    assert_new_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (new_result_i && !cal_done_i && !mode_wr_i) |=> !rdy_n_o);

    // R4: the blanking window drops an unread result's indicator.
    assert_blank_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RF_VALID && in_window && !new_result_i && !cal_done_i && !mode_wr_i)
        |=> (rdy_n_o && state_o == 2'd2));

    // R6: calibration completion always lands in the hold with the indicator low.
    assert_cal_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_i |=> (!rdy_n_o && state_o == 2'd3));

    // R7: the hold persists until a mode write.
    assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RF_CALHOLD && !mode_wr_i) |=> (state_q == RF_CALHOLD));

    // R8: a mode write without calibration-done returns to idle.
    assert_mode_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && !cal_done_i) |=> (rdy_n_o && state_o == 2'd0));

    // R10: a read while the indicator is high leaves the state alone.
    assert_read_noeffect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_n_o && read_done_i && !new_result_i && !cal_done_i && !mode_wr_i)
        |=> $stable(state_q));

endmodule

// File: tb/test_rdy_flag_ctrl.sv
`timescale 1ns/1ps
module test_rdy_flag_ctrl;

    localparam int CNT_W = 8;
    localparam int BLANK = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             new_result, read_done, cal_done, mode_wr;
    logic [CNT_W-1:0] upd_cnt;
    logic             rdy_n, rdy_stat;
    logic [1:0]       state;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rdy_flag_ctrl #(.CNT_W(CNT_W), .BLANK_CLKS(BLANK)) i_rdy_flag_ctrl (
        .clk(clk), .rst_n(rst_n),
        .new_result_i(new_result), .read_done_i(read_done),
        .cal_done_i(cal_done), .mode_wr_i(mode_wr),
        .upd_cnt_i(upd_cnt),
        .rdy_n_o(rdy_n), .rdy_stat_o(rdy_stat), .state_o(state)
    );

    // Expected successor state computed from the requirement text.
    function automatic logic [1:0] model(input logic [1:0] s, input logic c, input logic m,
                                         input logic n, input logic r, input logic [CNT_W-1:0] k);
        logic hit;
        hit = (k != 0) && (int'(k) <= BLANK);
        if (c)              return 2'd3;
        if (s == 2'd3)      return m ? 2'd0 : 2'd3;
        if (m)              return 2'd0;
        if (n)              return 2'd1;
        if (s == 2'd1 && hit) return 2'd2;
        if (s == 2'd1 && r) return 2'd0;
        return s;
    endfunction

    // Requirement tag for the rule that governs a vector.
    function automatic string tag(input logic [1:0] s, input logic c, input logic m,
                                  input logic n, input logic r, input logic [CNT_W-1:0] k);
        logic hit;
        hit = (k != 0) && (int'(k) <= BLANK);
        if (c)                  return "R6";
        if (s == 2'd3)          return m ? "R8" : "R7";
        if (m)                  return "R8";
        if (n && r)             return "R9";
        if (n && hit)           return "R9";
        if (n)                  return "R2";
        if (s == 2'd1 && hit)   return "R4";
        if (s == 2'd1 && r)     return "R3";
        if (r)                  return "R10";
        return "R5";
    endfunction

    task automatic drive(input logic c, input logic m, input logic n, input logic r,
                         input logic [CNT_W-1:0] k);
        cal_done = c; mode_wr = m; new_result = n; read_done = r; upd_cnt = k;
        @(posedge clk);
        @(negedge clk);
        cal_done = 0; mode_wr = 0; new_result = 0; read_done = 0; upd_cnt = '0;
    endtask

    task automatic check(input string req, input logic [1:0] exp_s);
        logic exp_rdy_n;
        exp_rdy_n = !(exp_s == 2'd1 || exp_s == 2'd3);
        n_checks++;
        if (state !== exp_s || rdy_n !== exp_rdy_n || rdy_stat !== !exp_rdy_n) begin
            n_fail++;
            $display("FAIL %s: state=%0d rdy_n=%0b stat=%0b expected state=%0d rdy_n=%0b stat=%0b",
                     req, state, rdy_n, rdy_stat, exp_s, exp_rdy_n, !exp_rdy_n);
        end
    endtask

    task automatic reach(input logic [1:0] s);
        drive(0, 1, 0, 0, '0);
        if (s == 2'd1 || s == 2'd2) drive(0, 0, 1, 0, '0);
        if (s == 2'd2)              drive(0, 0, 0, 0, 8'd1);
        if (s == 2'd3)              drive(1, 0, 0, 0, '0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [CNT_W-1:0] cnts [5];
        cnts[0] = 8'd0; cnts[1] = 8'd1; cnts[2] = 8'(BLANK);
        cnts[3] = 8'(BLANK + 1); cnts[4] = 8'd255;
        cal_done = 0; mode_wr = 0; new_result = 0; read_done = 0; upd_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 2'd0);

        // Exhaustive sweep: every start state, strobe combination and window-edge count.
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 16; v++) begin
                for (int ci = 0; ci < 5; ci++) begin
                    logic c, m, n, r;
                    c = v[3]; m = v[2]; n = v[1]; r = v[0];
                    reach(2'(s));
                    check("R11", 2'(s));
                    drive(c, m, n, r, cnts[ci]);
                    check(tag(2'(s), c, m, n, r, cnts[ci]),
                          model(2'(s), c, m, n, r, cnts[ci]));
                end
            end
        end

        // R4: blanked state persists through idle cycles and reads, ends on a new result.
        reach(2'd2);
        for (int i = 0; i < 6; i++) begin
            drive(0, 0, 0, i[0], '0);
            check("R4", 2'd2);
        end
        drive(0, 0, 1, 0, '0);
        check("R4", 2'd1);

        // R7: long calibration hold ignores reads and results, releases on mode write.
        reach(2'd3);
        for (int i = 0; i < 6; i++) begin
            drive(0, 0, i[0], !i[0], 8'(i));
            check("R7", 2'd3);
        end
        drive(0, 1, 0, 0, '0);
        check("R8", 2'd0);

        // R1: reset from the hold returns to idle.
        reach(2'd3);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", 2'd0);
        rst_n = 1'b1;

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule